// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt events from a set of single-owner sources, one group of port pins and one non-maskable input. Every event is latched into a flag bit. A flag stays set until software clears it or the CPU enters the routine that serves it. Software controls a per-source enable mask, a global enable and a separate enable for the non-maskable input through a small register interface. Flags are cleared by writing ones.

Each cycle the controller takes the lowest-numbered vector that is both pending and allowed. It presents that vector's number and its byte address to the CPU through a request, acknowledge and return handshake.

- On acknowledge, the controller clears the global enable. If the vector has a single owner, it also clears that source's flag.
- On return, the controller sets the global enable again. It then holds back every request until the CPU reports that one main-program instruction has retired.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset all source enables, the global enable (CTRL bit 0), the non-maskable enable (CTRL bit 1), all flags and `irq_req` are 0.
- R2: An event pulse sets its flag at the next clock edge, whatever the state of the enables. Flags read back on `rd_sel`=1 (bit 0 non-maskable, bit 1+i source i) and `rd_sel`=2 (bit j pin j).
- R3: A write to select 1 or 2 clears each flag whose data bit is 1 and leaves flags with a 0 bit unchanged. An event on the same flag in the same cycle keeps it set.
- R4: A maskable vector requests only when its flag, its enable bit and the global enable are all set. `irq_req` rises one edge after those conditions hold.
- R5: The vectors are numbered as follows: 2 for the non-maskable input, 3+i for source i, and 3+N_SRC for the pin group. The lowest pending, allowed number is presented.
- R6: The non-maskable vector requests whenever its flag and its own enable are set, regardless of the global enable.
- R7: `irq_addr` equals 4*(`irq_vec`-1).
- R8: `irq_ack` while `irq_req` is high clears the global enable. It clears the flag of the presented vector when that vector has a single owner, and it drops `irq_req` for the next cycle.
- R9: The pins of the group share enable bit N_SRC (select 0) and one vector. Entry leaves their flags untouched.
- R10: `reti` sets the global enable. No request is raised from the edge of `reti` until the edge of the next `instr_retire` pulse.
- R11: `irq_ack` while `irq_req` is low changes nothing.
- R12: Repeated events on a source before service merge into one flag and yield one service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | N_SRC | Event pulses of the single-owner sources |
| pin_evt | input | GRP_PINS | Event pulses of the grouped port pins |
| nmi_evt | input | 1 | Non-maskable event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 enables, 1 flag clear, 2 pin flag clear, 3 control |
| wr_data | input | DW | Write data |
| rd_sel | input | 2 | Read select, same map as `wr_sel` |
| rd_data | output | DW | Read data (combinational) |
| irq_ack | input | 1 | CPU pulse at routine entry |
| reti | input | 1 | CPU pulse at return from interrupt |
| instr_retire | input | 1 | CPU pulse per retired main-program instruction |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | VEC_W | Presented vector number |
| irq_addr | output | ADDR_W | Byte address of the presented vector |

## Verification
Two functions can fall in the same cycle. The first is the entry acknowledge, which clears the presented flag and the global enable. The second is the arrival of a new event, either on the very source being acknowledged or on the higher-ranked non-maskable input.

The bench drives `irq_ack` and `nmi_evt` in the same cycle. It then reads back the flags and the next presented vector, expecting the acknowledged flag gone, the new event kept, and the non-maskable vector requested despite the cleared global enable. Random mixes of events and masks are also judged against a bench priority function.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

   typedef enum logic [1:0] {
      RA_EN   = 2'd0,
      RA_FLAG = 2'd1,
      RA_PIN  = 2'd2,
      RA_CTRL = 2'd3
   } reg_sel_e;

   localparam int unsigned CTRL_GIE  = 0;
   localparam int unsigned CTRL_NMIE = 1;
   localparam int unsigned VEC_NMI   = 2;
   localparam int unsigned VEC_FIRST = 3;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned vec_byte_addr(input int unsigned vec);
      return 4 * (vec - 1);
   endfunction

endpackage

// File: rtl/pvic_flag_bank.sv
module pvic_flag_bank #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] w1c_i,
   input  logic [N-1:0] ack_clr_i,
   output logic [N-1:0] flags_o
);

   generate
      for (genvar b = 0; b < int'(N); b++) begin : g_bit
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)         q <= 1'b0;
            else if (set_i[b])  q <= 1'b1;
            else if (w1c_i[b] || ack_clr_i[b]) q <= 1'b0;
         end
         assign flags_o[b] = q;
      end
   endgenerate

endmodule

// File: rtl/pvic_prio_pick.sv
module pvic_prio_pick #(
   parameter int unsigned N     = 6,
   parameter int unsigned IDX_W = 3
) (
   input  logic [N-1:0]     req_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      for (int i = int'(N) - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            valid_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/pvic_seq.sv
module pvic_seq #(
   parameter int unsigned VEC_W  = 3,
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cand_valid,
   input  logic [VEC_W-1:0]  cand_vec,
   input  logic              ack_eff,
   input  logic              reti,
   input  logic              instr_retire,
   input  logic              gie_wr,
   input  logic              gie_wdata,
   output logic              gie_o,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec,
   output logic [ADDR_W-1:0] irq_addr
);

   logic guard_q, guard_d;
   logic gie_q;

   always_comb begin
      guard_d = guard_q;
      if (reti)              guard_d = 1'b1;
      else if (instr_retire) guard_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie_q   <= 1'b0;
         guard_q <= 1'b0;
         irq_req <= 1'b0;
         irq_vec <= VEC_W'(pvic_pkg::VEC_NMI);
      end else begin
         guard_q <= guard_d;
         if (ack_eff)     gie_q <= 1'b0;
         else if (reti)   gie_q <= 1'b1;
         else if (gie_wr) gie_q <= gie_wdata;
         if (ack_eff) begin
            irq_req <= 1'b0;
         end else begin
            irq_req <= cand_valid && !guard_d;
            if (cand_valid && !guard_d) irq_vec <= cand_vec;
         end
      end
   end

   assign gie_o    = gie_q;
   assign irq_addr = ADDR_W'(pvic_pkg::vec_byte_addr(int'(irq_vec)));

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
   parameter  int unsigned N_SRC    = 4,
   parameter  int unsigned GRP_PINS = 4,
   parameter  int unsigned ADDR_W   = 16,
   localparam int unsigned DW       = pvic_pkg::max2(N_SRC + 1, pvic_pkg::max2(GRP_PINS, 2)),
   localparam int unsigned VEC_W    = $clog2(N_SRC + 4)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_SRC-1:0]    src_evt,
   input  logic [GRP_PINS-1:0] pin_evt,
   input  logic                nmi_evt,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [DW-1:0]       wr_data,
   input  logic [1:0]          rd_sel,
   output logic [DW-1:0]       rd_data,
   input  logic                irq_ack,
   input  logic                reti,
   input  logic                instr_retire,
   output logic                irq_req,
   output logic [VEC_W-1:0]    irq_vec,
   output logic [ADDR_W-1:0]   irq_addr
);
   import pvic_pkg::*;

   localparam int unsigned NSGL  = N_SRC + 1;
   localparam int unsigned NREQ  = N_SRC + 2;

   generate
      if (N_SRC < 1) begin : g_bad_nsrc
         $error("N_SRC must be at least 1");
      end
      if (GRP_PINS < 1) begin : g_bad_grp
         $error("GRP_PINS must be at least 1");
      end
      if (ADDR_W < VEC_W + 2) begin : g_bad_addr
         $error("ADDR_W too narrow for the vector addresses");
      end
   endgenerate

   logic [NSGL-1:0]     en_q;
   logic                nmie_q;
   logic                gie;
   logic [NSGL-1:0]     sgl_flags, sgl_w1c, sgl_ack_clr;
   logic [GRP_PINS-1:0] pin_flags, pin_w1c;
   logic [NREQ-1:0]     req_vec;
   logic                cand_valid;
   logic [VEC_W-1:0]    cand_idx, cand_vec;
   logic                ack_eff;

   assign ack_eff = irq_ack && irq_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         nmie_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_sel == RA_EN)   en_q   <= wr_data[NSGL-1:0];
         if (wr_sel == RA_CTRL) nmie_q <= wr_data[CTRL_NMIE];
      end
   end

   assign sgl_w1c = (wr_en && wr_sel == RA_FLAG) ? wr_data[NSGL-1:0]     : '0;
   assign pin_w1c = (wr_en && wr_sel == RA_PIN)  ? wr_data[GRP_PINS-1:0] : '0;

   generate
      for (genvar i = 0; i < int'(NSGL); i++) begin : g_ackclr
         assign sgl_ack_clr[i] = ack_eff && (irq_vec == VEC_W'(i + VEC_NMI));
      end
   endgenerate

   pvic_flag_bank #(.N(NSGL)) i_sgl_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     ({src_evt, nmi_evt}),
      .w1c_i     (sgl_w1c),
      .ack_clr_i (sgl_ack_clr),
      .flags_o   (sgl_flags)
   );

   pvic_flag_bank #(.N(GRP_PINS)) i_pin_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (pin_evt),
      .w1c_i     (pin_w1c),
      .ack_clr_i ('0),
      .flags_o   (pin_flags)
   );

   assign req_vec[0] = sgl_flags[0] && nmie_q;
   generate
      for (genvar i = 0; i < int'(N_SRC); i++) begin : g_mreq
         assign req_vec[i+1] = sgl_flags[i+1] && en_q[i] && gie;
      end
   endgenerate
   assign req_vec[NREQ-1] = (|pin_flags) && en_q[N_SRC] && gie;

   pvic_prio_pick #(.N(NREQ), .IDX_W(VEC_W)) i_pick (
      .req_i   (req_vec),
      .valid_o (cand_valid),
      .idx_o   (cand_idx)
   );

   assign cand_vec = cand_idx + VEC_W'(VEC_NMI);

   pvic_seq #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cand_valid   (cand_valid),
      .cand_vec     (cand_vec),
      .ack_eff      (ack_eff),
      .reti         (reti),
      .instr_retire (instr_retire),
      .gie_wr       (wr_en && wr_sel == RA_CTRL),
      .gie_wdata    (wr_data[CTRL_GIE]),
      .gie_o        (gie),
      .irq_req      (irq_req),
      .irq_vec      (irq_vec),
      .irq_addr     (irq_addr)
   );

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         RA_EN:   rd_data = DW'(en_q);
         RA_FLAG: rd_data = DW'(sgl_flags);
         RA_PIN:  rd_data = DW'(pin_flags);
         default: begin
            rd_data[CTRL_GIE]  = gie;
            rd_data[CTRL_NMIE] = nmie_q;
         end
      endcase
   end

endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
   parameter int unsigned N_SRC = 4,
   parameter int unsigned VEC_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_ack,
   input logic             reti,
   input logic             instr_retire,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic             irq_req,
   input logic [VEC_W-1:0] irq_vec,
   input logic             gie,
   input logic             nmie
);
   import pvic_pkg::*;

   logic blocked;
   always_ff @(posedge clk) begin
      if (!rst_n)            blocked <= 1'b0;
      else if (reti)         blocked <= 1'b1;
      else if (instr_retire) blocked <= 1'b0;
   end

   a_r4_gie_gates_maskable: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_vec != VEC_W'(VEC_NMI)) |-> $past(gie));

   a_r5_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec >= VEC_W'(VEC_NMI) && irq_vec <= VEC_W'(N_SRC + VEC_FIRST)));

   a_r6_nmi_needs_own_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_vec == VEC_W'(VEC_NMI)) |-> $past(nmie));

   a_r8_entry_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> !gie);

   a_r8_entry_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> !irq_req);

   a_r10_retire_guard: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |-> !irq_req);

   a_r11_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !irq_req && !reti && !(wr_en && wr_sel == RA_CTRL)) |=> (gie == $past(gie)));

endmodule

bind prio_vec_intc pvic_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) i_pvic_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq_ack      (irq_ack),
   .reti         (reti),
   .instr_retire (instr_retire),
   .wr_en        (wr_en),
   .wr_sel       (wr_sel),
   .irq_req      (irq_req),
   .irq_vec      (irq_vec),
   .gie          (gie),
   .nmie         (nmie_q)
);

// File: tb/test_prio_vec_intc.sv
`timescale 1ns/1ps
module test_prio_vec_intc;
   localparam int unsigned N_SRC = 4;
   localparam int unsigned GRP   = 4;
   localparam int unsigned AW    = 16;
   localparam int unsigned DW    = 5;
   localparam int unsigned VW    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N_SRC-1:0] src_evt = '0;
   logic [GRP-1:0]   pin_evt = '0;
   logic nmi_evt = 1'b0, wr_en = 1'b0, irq_ack = 1'b0, reti = 1'b0, instr_retire = 1'b0;
   logic [1:0] wr_sel = '0, rd_sel = '0;
   logic [DW-1:0] wr_data = '0, rd_data;
   logic irq_req;
   logic [VW-1:0] irq_vec;
   logic [AW-1:0] irq_addr;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   prio_vec_intc #(.N_SRC(N_SRC), .GRP_PINS(GRP), .ADDR_W(AW)) i_prio_vec_intc (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .pin_evt(pin_evt), .nmi_evt(nmi_evt),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .irq_ack(irq_ack), .reti(reti), .instr_retire(instr_retire),
      .irq_req(irq_req), .irq_vec(irq_vec), .irq_addr(irq_addr));

   task automatic tick(); @(negedge clk); endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d; tick(); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [DW-1:0] d);
      rd_sel = sel; #0.1; d = rd_data;
   endtask

   task automatic pulse_ack();  irq_ack = 1'b1; tick(); irq_ack = 1'b0; endtask
   task automatic pulse_reti(); reti = 1'b1; tick(); reti = 1'b0; endtask
   task automatic pulse_ret();  instr_retire = 1'b1; tick(); instr_retire = 1'b0; endtask

   task automatic clean();
      pulse_reti(); pulse_ret();
      wr(2'd0, '0); wr(2'd3, '0); wr(2'd1, '1); wr(2'd2, '1);
   endtask

   function automatic int exp_vec(input logic [N_SRC-1:0] s, input logic [GRP-1:0] p,
                                  input logic n, input logic [N_SRC:0] en, input logic nmie);
      if (n && nmie) return 2;
      for (int i = 0; i < int'(N_SRC); i++) if (s[i] && en[i]) return 3 + i;
      if ((|p) && en[N_SRC]) return 3 + N_SRC;
      return 0;
   endfunction

   initial begin
      #(5.0 * 20000);
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      void'($urandom(32'h5eed_1234));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      rd(2'd0, d); chk("R1 enables", d, 0);
      rd(2'd3, d); chk("R1 control", d, 0);
      rd(2'd1, d); chk("R1 flags", d, 0);
      rd(2'd2, d); chk("R1 pin flags", d, 0);
      chk("R1 irq_req", irq_req, 0);

      // R2 flag latches while masked
      src_evt[1] = 1'b1; tick(); src_evt[1] = 1'b0;
      rd(2'd1, d); chk("R2 masked flag latched", d, 5'b00100);
      tick(); chk("R2 no request while masked", irq_req, 0);

      // R3 write-one-to-clear
      wr(2'd1, 5'b00000); rd(2'd1, d); chk("R3 write zero keeps", d, 5'b00100);
      wr(2'd1, 5'b00100); rd(2'd1, d); chk("R3 write one clears", d, 0);
      src_evt[1] = 1'b1; wr(2'd1, 5'b00100); src_evt[1] = 1'b0;
      rd(2'd1, d); chk("R3 event beats clear", d, 5'b00100);

      // R4/R7 maskable request
      wr(2'd0, 5'b00010); tick(); chk("R4 no request without gie", irq_req, 0);
      wr(2'd3, 5'b00001); tick();
      chk("R4 request", irq_req, 1); chk("R5 src1 vector", irq_vec, 4); chk("R7 address", irq_addr, 12);

      // R5 priority, R6 nmi enable
      src_evt[0] = 1'b1; tick(); src_evt[0] = 1'b0;
      wr(2'd0, 5'b00011); tick(); chk("R5 src0 wins", irq_vec, 3);
      nmi_evt = 1'b1; tick(); nmi_evt = 1'b0; tick();
      chk("R6 nmi needs own enable", irq_vec, 3);
      wr(2'd3, 5'b00011); tick();
      chk("R5 nmi top", irq_vec, 2); chk("R7 nmi address", irq_addr, 4);

      // R8 entry
      pulse_ack();
      rd(2'd1, d); chk("R8 nmi flag cleared", d, 5'b00110);
      rd(2'd3, d); chk("R8 gie cleared", d, 5'b00010);
      chk("R8 req dropped", irq_req, 0);
      tick(); chk("R4 maskables held by gie", irq_req, 0);
      nmi_evt = 1'b1; tick(); nmi_evt = 1'b0; tick();
      chk("R6 nmi ignores gie", irq_req, 1); chk("R6 nmi vector", irq_vec, 2);
      pulse_ack();

      // R10 return and guard, R11 stray ack
      pulse_reti();
      rd(2'd3, d); chk("R10 gie set by reti", d, 5'b00011);
      chk("R10 guard blocks", irq_req, 0);
      pulse_ack();
      rd(2'd3, d); chk("R11 stray ack ignored", d, 5'b00011);
      tick(); chk("R10 still blocked", irq_req, 0);
      pulse_ret();
      chk("R10 request after retire", irq_req, 1); chk("R10 vector after retire", irq_vec, 3);

      // same cycle: entry plus new higher event
      irq_ack = 1'b1; nmi_evt = 1'b1; tick(); irq_ack = 1'b0; nmi_evt = 1'b0;
      rd(2'd1, d); chk("R8 acked flag cleared, new kept", d, 5'b00101);
      tick(); chk("R6 nmi follows entry", irq_vec, 2); chk("R6 nmi req", irq_req, 1);
      irq_ack = 1'b1; nmi_evt = 1'b1; tick(); irq_ack = 1'b0; nmi_evt = 1'b0;
      rd(2'd1, d); chk("R3 event beats entry clear", d, 5'b00101);

      // R9 group
      clean();
      pin_evt = 4'b0101; tick(); pin_evt = '0;
      wr(2'd0, 5'b10000); wr(2'd3, 5'b00001); tick();
      chk("R9 group vector", irq_vec, 7); chk("R7 group address", irq_addr, 24);
      pulse_ack();
      rd(2'd2, d); chk("R9 pin flags kept", d, 5'b00101);

      // R12 merging
      clean();
      src_evt[2] = 1'b1; tick(); src_evt[2] = 1'b0; tick();
      src_evt[2] = 1'b1; tick(); src_evt[2] = 1'b0;
      wr(2'd0, 5'b00100); wr(2'd3, 5'b00001); tick();
      chk("R12 one request", irq_vec, 5);
      pulse_ack(); pulse_reti(); pulse_ret(); tick();
      chk("R12 no second service", irq_req, 0);

      // random mixes, R5/R6/R2
      for (int it = 0; it < 60; it++) begin
         logic [N_SRC-1:0] s; logic [GRP-1:0] p; logic n, ne; logic [N_SRC:0] en; int ev;
         clean();
         s = N_SRC'($urandom); p = GRP'($urandom); n = 1'($urandom);
         en = (N_SRC+1)'($urandom); ne = 1'($urandom);
         src_evt = s; pin_evt = p; nmi_evt = n; tick();
         src_evt = '0; pin_evt = '0; nmi_evt = 1'b0;
         rd(2'd1, d); chk("R2 random flags", d, {s, n});
         wr(2'd0, en); wr(2'd3, {3'b0, ne, 1'b1}); tick();
         ev = exp_vec(s, p, n, en, ne);
         chk("R5 random request", irq_req, (ev != 0));
         if (ev != 0) chk("R5 random vector", irq_vec, ev);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule